// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block is an 8 KB data cache between a CPU load/store port and a 64-bit external memory bus. Storage is split into two ways of 128 lines each, with 32-byte lines. Each way is indexed like a small direct-mapped array, and a one-bit least-recently-used marker per set picks which way to replace. CPU accesses are whole 64-bit words.

A read that hits is accepted at once and its data comes back on the next cycle. A read that misses holds the CPU off. First, any writes still waiting to go out are sent to memory. Then one line request is issued, and the line comes back as four 64-bit beats that fill the chosen way. After that the read completes as a hit.

Writes are write-through. Every accepted write enters a four-entry write buffer that drains to memory in order. A write that hits also updates the cached word. A write that misses never allocates a line.

The CPU request channel is valid/ready. The CPU holds `req_write`, `req_addr` and `req_wdata` stable while `req_valid` is high and `req_ready` is low. A request is taken on a cycle where both are high.

The memory side has three parts:
- **Write channel.** `mem_wr_valid` stays high with a stable address and data until `mem_wr_ready` is seen.
- **Line request.** The request is held the same way until `mem_rd_ready` is seen.
- **Returning beats.** These have no back-pressure. The cache takes one beat in every cycle where `mem_rd_data_valid` is high. Memory must send exactly four beats per request and none outside a request.

Top module: `l1d_wt_cache`

## Requirements
- R1: A synchronous reset invalidates every line in both ways and empties the write buffer. After reset, `rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are low, and the first read of any address misses.
- R2: Address fields are as follows:
  - bits [4:3] select the 64-bit word within a line;
  - bits [11:5] select one of 128 sets;
  - bits [31:12] form the tag;
  - bits [2:0] are ignored for lookup.

  Two lines with the same set index and different tags can be resident together, one per way.
- R3: A read that hits has `req_ready` high in the same cycle. It gives `rsp_valid` high with the word one cycle after acceptance, and it causes no line request.
- R4: A read that misses keeps `req_ready` low and issues exactly one line request at the line-aligned address. Memory returns four beats in ascending address order: beat k holds the bytes at the line address plus 8k and becomes word k of the line. The read then completes with the requested word.
- R5: A write that hits updates the cached word and is also sent to memory. Later reads of that address return the new value without a line request.
- R6: A write that misses is sent to memory and allocates no line. A later read of that address misses and returns the written value.
- R7: The write buffer holds four writes and sends them to memory in acceptance order. A write is held off only while all four entries are occupied.
- R8: A line request is issued only after every write accepted before the miss has been taken by memory.
- R9: A refill uses an invalid way of the set if one exists. Otherwise it uses the way not accessed most recently; read hits, write hits and refills all count as accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | CPU request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the 64-bit word |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read is accepted |
| rsp_rdata | output | 64 | Read data |
| mem_wr_valid | output | 1 | Write-through entry presented to memory |
| mem_wr_ready | input | 1 | Memory takes the presented write |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 64 | Write data |
| mem_rd_valid | output | 1 | Line request presented |
| mem_rd_ready | input | 1 | Memory takes the line request |
| mem_rd_addr | output | 32 | Line-aligned request address |
| mem_rd_data_valid | input | 1 | One refill beat present |
| mem_rd_data | input | 64 | Refill beat data |

## Verification
The main table mixes several access patterns within a single set:
- repeated reads to one line, which separate hits from misses by counting line requests;
- reads of word 3 after a refill triggered on word 0, which expose a wrong beat order or word placement;
- a third tag rotating through two resident tags, which shows whether the less recently used way is the one evicted;
- a write hit followed by a read of the same word, and a write miss followed by a read of that address, which separate the update and no-allocate policies.

Reads of set 0 and set 127 check the index and tag boundaries. Directed tests then hold the memory write channel off. With the buffer held full, they check the write stall and the order in which memory sees the writes. With a write pending, they confirm that no line request leaves until that write has reached memory.

// File: rtl/l1d_pkg.sv
package l1d_pkg;
  localparam int unsigned L1D_ADDR_W     = 32;
  localparam int unsigned L1D_DATA_W     = 64;
  localparam int unsigned L1D_SETS       = 128;
  localparam int unsigned L1D_LINE_BYTES = 32;
  localparam int unsigned L1D_WB_DEPTH   = 4;

  typedef enum logic [1:0] {
    RF_IDLE,
    RF_DRAIN,
    RF_ADDR,
    RF_BEATS
  } refill_st_e;
endpackage

// File: rtl/l1d_tag_store.sv
module l1d_tag_store #(
  parameter int unsigned SETS  = 128,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       hit_vec,
  output logic             victim,
  input  logic             touch,
  input  logic             touch_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_way
);
  logic [1:0]      way_vld;
  logic [SETS-1:0] lru_next_victim;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  vbits;

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tags[fill_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) vbits <= '0;
      else if (fill_en && fill_way == 1'(w)) vbits[fill_idx] <= 1'b1;
    end

    assign way_vld[w] = vbits[lk_idx];
    assign hit_vec[w] = way_vld[w] && (tags[lk_idx] == lk_tag);
  end

  // Invalid way first, otherwise the stored replacement choice.
  always_comb begin
    if (!way_vld[0])      victim = 1'b0;
    else if (!way_vld[1]) victim = 1'b1;
    else                  victim = lru_next_victim[lk_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) lru_next_victim <= '0;
    else if (fill_en) lru_next_victim[fill_idx] <= ~fill_way;
    else if (touch)   lru_next_victim[lk_idx]   <= ~touch_way;
  end

  AST_ONE_WAY_HITS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R9
  AST_VICTIM_PREFERS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!way_vld[0] |-> !victim)); // R9
endmodule

// File: rtl/l1d_line_store.sv
module l1d_line_store #(
  parameter int unsigned SETS   = 128,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned WSEL_W = $clog2(WORDS),
  localparam int unsigned LOC_W  = 1 + IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              w_way,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WSEL_W-1:0] w_word,
  input  logic [DATA_W-1:0] w_data,
  input  logic              r_way,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [WSEL_W-1:0] r_word,
  output logic [DATA_W-1:0] r_data
);
  logic [DATA_W-1:0] words [2*SETS*WORDS];
  logic [LOC_W-1:0]  w_loc;
  logic [LOC_W-1:0]  r_loc;

  assign w_loc  = {w_way, w_idx, w_word};
  assign r_loc  = {r_way, r_idx, r_word};
  assign r_data = words[r_loc];

  always_ff @(posedge clk) begin
    if (we) words[w_loc] <= w_data;
  end
endmodule

// File: rtl/l1d_write_buf.sv
module l1d_write_buf #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic              empty,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wentry_t;

  wentry_t        slots [DEPTH];
  logic [PW-1:0]  wr_p;
  logic [PW-1:0]  rd_p;
  logic [PW:0]    fill;
  logic           pop;

  assign full      = (fill == (PW+1)'(DEPTH));
  assign empty     = (fill == '0);
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;
  assign out_addr  = slots[rd_p].addr;
  assign out_data  = slots[rd_p].data;

  always_ff @(posedge clk) begin
    if (push) slots[wr_p] <= '{addr: push_addr, data: push_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p <= '0;
      rd_p <= '0;
      fill <= '0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  AST_WB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push |-> !full)); // R7
  AST_WB_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data))); // R7
endmodule

// File: rtl/l1d_refill.sv
module l1d_refill
  import l1d_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss,
  input  logic [IDX_W-1:0]  miss_idx,
  input  logic [TAG_W-1:0]  miss_tag,
  input  logic              victim_in,
  input  logic              wb_empty,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              beat_valid,
  output logic              beat_we,
  output logic [WSEL_W-1:0] beat_word,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              fill_way
);
  refill_st_e        st;
  logic [WSEL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RF_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        RF_IDLE: if (miss) st <= RF_DRAIN;
        RF_DRAIN: if (wb_empty) st <= RF_ADDR;
        RF_ADDR: if (rd_req_ready) begin
          st  <= RF_BEATS;
          cnt <= '0;
        end
        RF_BEATS: if (beat_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == WSEL_W'(WORDS-1)) st <= RF_IDLE;
        end
        default: st <= RF_IDLE;
      endcase
    end
  end

  // Capture the missing line and its destination way on detection.
  always_ff @(posedge clk) begin
    if (st == RF_IDLE && miss) begin
      fill_idx <= miss_idx;
      fill_tag <= miss_tag;
      fill_way <= victim_in;
    end
  end

  assign busy         = (st != RF_IDLE);
  assign rd_req_valid = (st == RF_ADDR);
  assign rd_req_addr  = {fill_tag, fill_idx, OFF_W'(0)};
  assign beat_we      = (st == RF_BEATS) && beat_valid;
  assign beat_word    = cnt;
  assign fill_en      = beat_we && (cnt == WSEL_W'(WORDS-1));

  AST_BURST_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid |-> wb_empty)); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr))); // R4
endmodule

// File: rtl/l1d_wt_cache.sv
module l1d_wt_cache
  import l1d_pkg::*;
#(
  parameter int unsigned ADDR_W     = L1D_ADDR_W,
  parameter int unsigned DATA_W     = L1D_DATA_W,
  parameter int unsigned SETS       = L1D_SETS,
  parameter int unsigned LINE_BYTES = L1D_LINE_BYTES,
  parameter int unsigned WB_DEPTH   = L1D_WB_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_data_valid,
  input  logic [DATA_W-1:0] mem_rd_data
);
  localparam int unsigned BYTE_W = $clog2(DATA_W/8);
  localparam int unsigned WORDS  = LINE_BYTES / (DATA_W/8);
  localparam int unsigned WSEL_W = $clog2(WORDS);
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic [WSEL_W-1:0] req_word;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [1:0]        hit_vec;
  logic              hit, hit_way, victim;
  logic              busy, wb_full, wb_empty;
  logic              accept, rd_accept, wr_accept, cpu_wr_hit, rd_miss;
  logic              beat_we, fill_en, fill_way;
  logic [WSEL_W-1:0] beat_word;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic              ds_we, ds_way;
  logic [IDX_W-1:0]  ds_idx;
  logic [WSEL_W-1:0] ds_word;
  logic [DATA_W-1:0] ds_wdata, ds_rdata;

  assign req_word = req_addr[OFF_W-1:BYTE_W];
  assign req_idx  = req_addr[OFF_W+IDX_W-1:OFF_W];
  assign req_tag  = req_addr[ADDR_W-1:OFF_W+IDX_W];

  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];

  // Reads wait for a hit; writes wait only for buffer space.
  assign req_ready  = !busy && (req_write ? !wb_full : hit);
  assign accept     = req_valid && req_ready;
  assign rd_accept  = accept && !req_write;
  assign wr_accept  = accept && req_write;
  assign cpu_wr_hit = wr_accept && hit;
  assign rd_miss    = req_valid && !req_write && !hit && !busy;

  l1d_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .lk_idx    (req_idx),
    .lk_tag    (req_tag),
    .hit_vec   (hit_vec),
    .victim    (victim),
    .touch     (accept && hit),
    .touch_way (hit_way),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_tag  (fill_tag),
    .fill_way  (fill_way)
  );

  l1d_refill #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WORDS(WORDS)) u_refill (
    .clk          (clk),
    .rst          (rst),
    .miss         (rd_miss),
    .miss_idx     (req_idx),
    .miss_tag     (req_tag),
    .victim_in    (victim),
    .wb_empty     (wb_empty),
    .busy         (busy),
    .rd_req_valid (mem_rd_valid),
    .rd_req_ready (mem_rd_ready),
    .rd_req_addr  (mem_rd_addr),
    .beat_valid   (mem_rd_data_valid),
    .beat_we      (beat_we),
    .beat_word    (beat_word),
    .fill_en      (fill_en),
    .fill_idx     (fill_idx),
    .fill_tag     (fill_tag),
    .fill_way     (fill_way)
  );

  l1d_write_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_accept),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .full      (wb_full),
    .empty     (wb_empty),
    .out_valid (mem_wr_valid),
    .out_ready (mem_wr_ready),
    .out_addr  (mem_wr_addr),
    .out_data  (mem_wr_data)
  );

  // Refill beats and CPU write hits never coincide: the CPU is held during refill.
  assign ds_we    = beat_we || cpu_wr_hit;
  assign ds_way   = beat_we ? fill_way    : hit_way;
  assign ds_idx   = beat_we ? fill_idx    : req_idx;
  assign ds_word  = beat_we ? beat_word   : req_word;
  assign ds_wdata = beat_we ? mem_rd_data : req_wdata;

  l1d_line_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_lines (
    .clk    (clk),
    .we     (ds_we),
    .w_way  (ds_way),
    .w_idx  (ds_idx),
    .w_word (ds_word),
    .w_data (ds_wdata),
    .r_way  (hit_way),
    .r_idx  (req_idx),
    .r_word (req_word),
    .r_data (ds_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= rd_accept;
  end

  always_ff @(posedge clk) begin
    if (rd_accept) rsp_rdata <= ds_rdata;
  end

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    (rd_accept |=> rsp_valid)); // R3
  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid |-> $past(rd_accept))); // R3
  AST_STALL_DURING_BURST: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid |-> !req_ready)); // R4
  AST_WRITE_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    (wr_accept && !hit |=> !mem_rd_valid)); // R6
endmodule

// File: tb/sim_l1d_wt_cache.sv
module sim_l1d_wt_cache;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wr_addr;
  logic [63:0] mem_wr_data;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_data_valid;
  logic [63:0] mem_rd_data;

  always #5 clk = ~clk;

  l1d_wt_cache u0 (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit wr_open = 1'b1;
  int wr_pushed = 0, wr_seen = 0, bursts = 0, drain_err = 0;
  logic [31:0] wr_log [32];
  logic [63:0] bmem [logic [31:0]];
  logic        rd_busy;
  logic [31:0] rd_line;
  int          beat;

  assign mem_rd_ready = 1'b1;
  assign mem_wr_ready = wr_open;

  function automatic logic [63:0] patt(logic [31:0] a);
    return {a ^ 32'hA5A5_0000, ~a};
  endfunction

  function automatic logic [63:0] memval(logic [31:0] a);
    if (bmem.exists(a)) return bmem[a];
    return patt(a);
  endfunction

  // Memory model: accepts line requests, returns four ascending beats, sinks writes.
  always @(posedge clk) begin
    if (rst) begin
      rd_busy <= 1'b0;
      mem_rd_data_valid <= 1'b0;
      beat <= 0;
    end else begin
      mem_rd_data_valid <= 1'b0;
      if (mem_rd_valid && mem_rd_ready) begin
        rd_line <= mem_rd_addr;
        rd_busy <= 1'b1;
        beat    <= 0;
        bursts  <= bursts + 1;
        if (wr_pushed != wr_seen) drain_err <= drain_err + 1;
      end else if (rd_busy) begin
        mem_rd_data_valid <= 1'b1;
        mem_rd_data <= memval(rd_line + 32'(8*beat));
        beat <= beat + 1;
        if (beat == 3) rd_busy <= 1'b0;
      end
      if (mem_wr_valid && mem_wr_ready) begin
        bmem[mem_wr_addr] = mem_wr_data;
        wr_log[wr_seen % 32] <= mem_wr_addr;
        wr_seen <= wr_seen + 1;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [31:0] a, logic [63:0] d,
                        output logic [63:0] rd, output bit rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) wr_pushed++;
    rd = rsp_rdata;
    rv = rsp_valid;
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [63:0] data;
    logic        use_patt;
    logic        burst;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0001_0060, 64'h0, 1'b1, 1'b1, 4'd4},                   // R4 first miss
    '{1'b0, 32'h0001_0078, 64'h0, 1'b1, 1'b0, 4'd4},                   // R4 word 3 placement
    '{1'b0, 32'h0001_0068, 64'h0, 1'b1, 1'b0, 4'd3},                   // R3 hit
    '{1'b1, 32'h0001_0070, 64'h1111_2222_3333_4444, 1'b0, 1'b0, 4'd5}, // R5 write hit
    '{1'b0, 32'h0001_0070, 64'h1111_2222_3333_4444, 1'b0, 1'b0, 4'd5}, // R5 read back
    '{1'b0, 32'h0002_0060, 64'h0, 1'b1, 1'b1, 4'd9},                   // R9 empty way
    '{1'b0, 32'h0001_0060, 64'h0, 1'b1, 1'b0, 4'd3},                   // R3 both resident
    '{1'b0, 32'h0003_0068, 64'h0, 1'b1, 1'b1, 4'd9},                   // R9 evicts older
    '{1'b0, 32'h0001_0070, 64'h1111_2222_3333_4444, 1'b0, 1'b0, 4'd9}, // R9 kept line
    '{1'b0, 32'h0002_0060, 64'h0, 1'b1, 1'b1, 4'd9},                   // R9 evicted line
    '{1'b1, 32'h0004_0078, 64'h5555_6666_7777_8888, 1'b0, 1'b0, 4'd6}, // R6 write miss
    '{1'b0, 32'h0001_0060, 64'h0, 1'b1, 1'b0, 4'd6},                   // R6 set untouched
    '{1'b0, 32'h0004_0078, 64'h5555_6666_7777_8888, 1'b0, 1'b1, 4'd6}, // R6 miss then value
    '{1'b0, 32'h0002_0060, 64'h0, 1'b1, 1'b1, 4'd9},                   // R9
    '{1'b0, 32'h0000_0000, 64'h0, 1'b1, 1'b1, 4'd2},                   // R2 set 0
    '{1'b0, 32'hFFFF_FFE0, 64'h0, 1'b1, 1'b1, 4'd2},                   // R2 set 127
    '{1'b0, 32'hFFFF_FFF8, 64'h0, 1'b1, 1'b0, 4'd2},                   // R2 word 3
    '{1'b0, 32'h0000_001F, 64'h0, 1'b1, 1'b0, 4'd2},                   // R2 low bits ignored
    '{1'b0, 32'h0000_1000, 64'h0, 1'b1, 1'b1, 4'd2},                   // R2 same set new tag
    '{1'b0, 32'h0000_0000, 64'h0, 1'b1, 1'b0, 4'd2}                    // R2 both ways live
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] rd, exp;
    bit rv;
    int b0, n0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    req_write = 1'b1; #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 write ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid low", 64'(rsp_valid), 64'd0);
    chk(!mem_rd_valid && !mem_wr_valid, "R1 memory idle", {62'd0, mem_rd_valid, mem_wr_valid}, 64'd0);
    req_write = 1'b0;

    for (int i = 0; i < NV; i++) begin
      b0  = bursts;
      exp = VEC[i].use_patt ? patt({VEC[i].addr[31:3], 3'b000}) : VEC[i].data;
      access(VEC[i].wr, VEC[i].addr, VEC[i].data, rd, rv);
      if (!VEC[i].wr)
        chk(rv && rd == exp, $sformatf("R%0d vec %0d data", VEC[i].rq, i), rd, exp);
      chk((bursts - b0) == int'(VEC[i].burst), $sformatf("R%0d vec %0d line requests", VEC[i].rq, i),
          64'(bursts - b0), 64'(VEC[i].burst));
    end

    // R5 write hit also reached memory
    repeat (4) @(negedge clk);
    chk(memval(32'h0001_0070) == 64'h1111_2222_3333_4444, "R5 forwarded to memory",
        memval(32'h0001_0070), 64'h1111_2222_3333_4444);

    // R7 buffer full stall and ordering
    wr_open = 1'b0;
    n0 = wr_seen;
    for (int k = 0; k < 4; k++) begin
      access(1'b1, 32'h0005_0120 + 32'(8*k), 64'(100 + k), rd, rv);
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0005_0200; req_wdata = 64'd104;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b0, "R7 fifth write held off", 64'(req_ready), 64'd0);
    wr_open = 1'b1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    wr_pushed++;
    for (int t = 0; t < 50 && wr_seen < n0 + 5; t++) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      logic [31:0] ea;
      ea = (k < 4) ? 32'h0005_0120 + 32'(8*k) : 32'h0005_0200;
      chk(wr_log[(n0 + k) % 32] == ea, $sformatf("R7 write order %0d", k), 64'(wr_log[(n0 + k) % 32]), 64'(ea));
    end

    // R8 drain before line request
    wr_open = 1'b0;
    access(1'b1, 32'h0006_0040, 64'hDEAD_BEEF_0000_0001, rd, rv);
    b0 = bursts;
    fork
      access(1'b0, 32'h0006_0040, 64'h0, rd, rv);
      begin
        repeat (8) @(negedge clk);
        #1;
        chk(bursts == b0, "R8 no line request while write pending", 64'(bursts), 64'(b0));
        chk(req_ready == 1'b0, "R4 CPU held during miss", 64'(req_ready), 64'd0);
        wr_open = 1'b1;
      end
    join
    chk(rv && rd == 64'hDEAD_BEEF_0000_0001, "R8 read sees drained write", rd, 64'hDEAD_BEEF_0000_0001);
    chk(drain_err == 0, "R8 no request with writes outstanding", 64'(drain_err), 64'd0);

    // R1 reset mid-run invalidates lines
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!rsp_valid && !mem_rd_valid && !mem_wr_valid, "R1 outputs idle after reset",
        {61'd0, rsp_valid, mem_rd_valid, mem_wr_valid}, 64'd0);
    b0 = bursts;
    access(1'b0, 32'h0001_0060, 64'h0, rd, rv);
    chk(bursts - b0 == 1, "R1 previously cached line misses", 64'(bursts - b0), 64'd1);
    chk(rv && rd == patt(32'h0001_0060), "R1 refilled data", rd, patt(32'h0001_0060));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule